// File: doc/BRIEF.md
# Delayed Write Completion Tracker

This block sits on the target side of a bus bridge and handles writes that the bridge completes as delayed transactions. When a write request arrives that matches no stored entry, the block captures its address, command, byte enables and data in a small queue, answers retry, and leaves forwarding to a master on the far bus. That master reports completion, good or failed, in allocation order. When the initiator repeats the write, the block compares the attempt with the stored entries. A pending entry is answered with retry again. A completed entry finishes with one data phase. A failed entry ends with a stop that carries no data.

The oldest entry in the queue is the head. Once the head holds a completion, a discard timer counts down from a preload value. If the initiator does not return before the count runs out, the entry is dropped. The block then sets a sticky flag and, when enabled, pulses a system-error request. After the head is consumed or dropped, the next entry to become head starts a new count.

Top module: `dwr_tracker`

## Requirements
- R1: A request that matches no valid entry is answered with retry and, if the slot at the write pointer is free, is stored as a new pending entry.
- R2: A repeat matches an entry when address, command and the 4-bit active-low byte enables are equal and the data agree on every enabled lane. Bit i of the enables governs data bits 8i+7..8i. Lanes whose enable bit is 1 are ignored, and a difference on an enabled lane means no match.
- R3: A repeat that matches a pending entry is answered with retry and takes no second slot.
- R4: A repeat that matches a completed entry gets trdy for one data phase, with stop only if the initiator asked for more than one DWORD. The entry is then released.
- R5: A repeat that matches an entry whose forwarding failed gets stop without trdy, and the entry is released.
- R6: `full` is 1 exactly when the slot at the write pointer is occupied. An unmatched request while full is retried without being stored.
- R7: The discard timer counts only while the head entry holds a completion. If the completion arrives at clock edge e, the discard takes effect at edge e+preload+1, unless a repeat consumes the entry first.
- R8: A discard sets the sticky `discard_seen`. It also pulses `serr_req` for one cycle only if `serr_en` was 1.
- R9: When the head is consumed at edge c and the next entry already holds a completion, that entry's discard falls at edge c+preload+2. Its count starts afresh and does not run from its own completion.
- R10: Each request gets exactly one response, at the clock edge that samples it, and no response is given without a request.
- R11: After reset, all responses, `serr_req`, `discard_seen` and `full` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | A write attempt is on the target bus this cycle |
| req_addr | input | 32 | Attempt address |
| req_cmd | input | 4 | Attempt bus command |
| req_be_n | input | 4 | Attempt byte enables, active low |
| req_data | input | 32 | Attempt write data |
| req_multi | input | 1 | Initiator wants more than one DWORD |
| fwd_done | input | 1 | Far-side completion for the oldest pending entry |
| fwd_err | input | 1 | Qualifies fwd_done as a failed delivery |
| discard_preload | input | 16 | Discard timer initial count |
| serr_en | input | 1 | Allows a discard to raise serr_req |
| rsp_valid | output | 1 | A response to an attempt is present |
| rsp_retry | output | 1 | Response is retry |
| rsp_trdy | output | 1 | Response moves one data phase |
| rsp_stop | output | 1 | Response asserts stop |
| serr_req | output | 1 | One-cycle system-error request on discard |
| discard_seen | output | 1 | Sticky: a completion was discarded |
| full | output | 1 | Next allocation slot is occupied |

## Verification
Responses are registered, so the result of an attempt is due at the edge that samples it. The bench drives attempts on the falling edge, queues the expected response, and has a monitor compare the outputs 1 time unit after each rising edge. Discard results are due preload+1 edges after the completing edge, or preload+2 edges after the previous head was consumed. The bench counts falling edges from the stimulus and checks `serr_req` one edge before, at, and one edge after the due edge. Static flags such as `full` are read on the falling edge that follows the attempt that changed them.

// File: rtl/dwr_pkg.sv
package dwr_pkg;
  parameter int ADDR_W = 32;
  parameter int DATA_W = 32;
  parameter int CMD_W  = 4;
  localparam int BE_W  = DATA_W / 8;

  typedef enum logic [1:0] {
    ST_PEND = 2'd0,
    ST_DONE = 2'd1,
    ST_FAIL = 2'd2
  } dwr_state_e;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [CMD_W-1:0]  cmd;
    logic [BE_W-1:0]   be_n;
    logic [DATA_W-1:0] data;
  } dwr_req_t;
endpackage

// File: rtl/dwr_rst_sync.sv
module dwr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= {sr_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sr_q[STAGES-1];
endmodule

// File: rtl/dwr_match.sv
module dwr_match
  import dwr_pkg::*;
(
  input  dwr_req_t stored,
  input  dwr_req_t probe,
  output logic     hit
);
  logic [BE_W-1:0] lane_ok;

  generate
    for (genvar l = 0; l < BE_W; l++) begin : g_lane
      // a lane whose enable is off (1) never blocks the match
      assign lane_ok[l] = probe.be_n[l] ||
                          (stored.data[8*l +: 8] == probe.data[8*l +: 8]);
    end
  endgenerate

  assign hit = (stored.addr == probe.addr) && (stored.cmd == probe.cmd) &&
               (stored.be_n == probe.be_n) && (&lane_ok);
endmodule

// File: rtl/dwr_discard_timer.sv
module dwr_discard_timer #(
  parameter int TMR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm,
  input  logic [TMR_W-1:0] preload,
  output logic             expire
);
  logic [TMR_W-1:0] cnt_q, cnt_d;

  always_comb begin
    if (!arm)              cnt_d = preload;
    else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
    else                   cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expire = arm && (cnt_q == '0);
endmodule

// File: rtl/dwr_tracker.sv
module dwr_tracker
  import dwr_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int TMR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [CMD_W-1:0]  req_cmd,
  input  logic [BE_W-1:0]   req_be_n,
  input  logic [DATA_W-1:0] req_data,
  input  logic              req_multi,
  input  logic              fwd_done,
  input  logic              fwd_err,
  input  logic [TMR_W-1:0]  discard_preload,
  input  logic              serr_en,
  output logic              rsp_valid,
  output logic              rsp_retry,
  output logic              rsp_trdy,
  output logic              rsp_stop,
  output logic              serr_req,
  output logic              discard_seen,
  output logic              full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  logic       rst_n_i;
  dwr_req_t   probe;
  dwr_req_t   ent_q [DEPTH];
  dwr_req_t   ent_d [DEPTH];
  dwr_state_e st_q  [DEPTH];
  dwr_state_e st_d  [DEPTH];
  logic [DEPTH-1:0] vld_q, vld_d, hit_raw;
  logic [PTR_W-1:0] wr_q, wr_d, rd_q, rd_d, cp_q, cp_d, hit_idx;
  logic any_hit, tmr_arm, tmr_expire;
  logic rv_d, rr_d, rt_d, rs_d, serr_d, seen_d;

  dwr_rst_sync #(.STAGES(2)) u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_i));

  assign probe = '{addr: req_addr, cmd: req_cmd, be_n: req_be_n, data: req_data};

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
      dwr_match u_match (.stored(ent_q[i]), .probe(probe), .hit(hit_raw[i]));
    end
  endgenerate

  assign tmr_arm = vld_q[rd_q] && (st_q[rd_q] != ST_PEND);

  dwr_discard_timer #(.TMR_W(TMR_W)) u_tmr (
    .clk(clk), .rst_n(rst_n_i), .arm(tmr_arm),
    .preload(discard_preload), .expire(tmr_expire)
  );

  always_comb begin
    vld_d = vld_q; st_d = st_q; ent_d = ent_q;
    wr_d = wr_q; rd_d = rd_q; cp_d = cp_q;
    rv_d = 1'b0; rr_d = 1'b0; rt_d = 1'b0; rs_d = 1'b0;
    serr_d = 1'b0; seen_d = discard_seen;
    any_hit = 1'b0; hit_idx = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (hit_raw[i] && vld_q[i] && !any_hit) begin
        any_hit = 1'b1;
        hit_idx = PTR_W'(i);
      end
    end
    if (fwd_done) begin
      st_d[cp_q] = fwd_err ? ST_FAIL : ST_DONE;
      cp_d = ptr_inc(cp_q);
    end
    if (req_valid) begin
      rv_d = 1'b1;
      if (any_hit) begin
        unique case (st_q[hit_idx])
          ST_DONE: begin rt_d = 1'b1; rs_d = req_multi; vld_d[hit_idx] = 1'b0; end
          ST_FAIL: begin rs_d = 1'b1; vld_d[hit_idx] = 1'b0; end
          default: rr_d = 1'b1;
        endcase
      end else begin
        rr_d = 1'b1;
        if (!vld_q[wr_q]) begin
          vld_d[wr_q] = 1'b1;
          st_d[wr_q]  = ST_PEND;
          ent_d[wr_q] = probe;
          wr_d = ptr_inc(wr_q);
        end
      end
    end
    if (tmr_expire && !(req_valid && any_hit && (hit_idx == rd_q))) begin
      vld_d[rd_q] = 1'b0;
      seen_d = 1'b1;
      serr_d = serr_en;
    end
    if (!vld_q[rd_q] && (rd_q != wr_q)) rd_d = ptr_inc(rd_q);
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      vld_q <= '0; wr_q <= '0; rd_q <= '0; cp_q <= '0;
      rsp_valid <= 1'b0; rsp_retry <= 1'b0; rsp_trdy <= 1'b0; rsp_stop <= 1'b0;
      serr_req <= 1'b0; discard_seen <= 1'b0;
    end else begin
      vld_q <= vld_d; wr_q <= wr_d; rd_q <= rd_d; cp_q <= cp_d;
      rsp_valid <= rv_d; rsp_retry <= rr_d; rsp_trdy <= rt_d; rsp_stop <= rs_d;
      serr_req <= serr_d; discard_seen <= seen_d;
    end
  end

  // payload and state need no reset: they are only read behind a valid bit
  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      ent_q[i] <= ent_d[i];
      st_q[i]  <= st_d[i];
    end
  end

  assign full = vld_q[wr_q];
endmodule

// File: rtl/dwr_tracker_chk.sv
module dwr_tracker_chk (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_multi,
  input logic serr_en,
  input logic rsp_valid,
  input logic rsp_retry,
  input logic rsp_trdy,
  input logic rsp_stop,
  input logic serr_req,
  input logic discard_seen
);
  assert_rsp_needs_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid));
  assert_req_gets_rsp_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  assert_retry_alone_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_retry |-> (rsp_valid && !rsp_trdy && !rsp_stop));
  assert_stop_with_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_trdy && rsp_stop) |-> $past(req_multi));
  assert_serr_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    serr_req |-> ($past(serr_en) && discard_seen));
  assert_serr_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    serr_req |=> !serr_req);
  assert_sticky_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(discard_seen));
endmodule

bind dwr_tracker dwr_tracker_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_multi(req_multi),
  .serr_en(serr_en), .rsp_valid(rsp_valid), .rsp_retry(rsp_retry),
  .rsp_trdy(rsp_trdy), .rsp_stop(rsp_stop), .serr_req(serr_req),
  .discard_seen(discard_seen)
);

// File: tb/dwr_tracker_bench.sv
module dwr_tracker_bench;
  localparam int CLK_PERIOD = 10;
  localparam int P = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_multi = 1'b0, fwd_done = 1'b0, fwd_err = 1'b0, serr_en = 1'b0;
  logic [31:0] req_addr = '0, req_data = '0;
  logic [3:0]  req_cmd = '0, req_be_n = '0;
  logic [15:0] discard_preload = 16'd1000;
  logic rsp_valid, rsp_retry, rsp_trdy, rsp_stop, serr_req, discard_seen, full;

  int vecs = 0, errs = 0;
  logic [2:0] exp_q[$];
  string      tag_q[$];
  logic [2:0] e;
  string      t;

  always #(CLK_PERIOD/2) clk = ~clk;

  dwr_tracker u_dwr_tracker (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_cmd(req_cmd), .req_be_n(req_be_n), .req_data(req_data), .req_multi(req_multi),
    .fwd_done(fwd_done), .fwd_err(fwd_err), .discard_preload(discard_preload),
    .serr_en(serr_en), .rsp_valid(rsp_valid), .rsp_retry(rsp_retry),
    .rsp_trdy(rsp_trdy), .rsp_stop(rsp_stop), .serr_req(serr_req),
    .discard_seen(discard_seen), .full(full)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // {retry, trdy, stop}
  task automatic send(logic [31:0] a, logic [3:0] be, logic [31:0] d, logic m,
                      logic [2:0] ex, string tag);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_cmd = 4'h7; req_be_n = be; req_data = d; req_multi = m;
    exp_q.push_back(ex); tag_q.push_back(tag);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic fwd(logic er);
    @(negedge clk); fwd_done = 1'b1; fwd_err = er;
    @(negedge clk); fwd_done = 1'b0; fwd_err = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  always @(posedge clk) begin
    #1;
    if (rsp_valid) begin
      vecs++;
      if (exp_q.size() == 0) begin
        errs++;
        $display("FAIL R10: unexpected response actual %b expected none",
                 {rsp_retry, rsp_trdy, rsp_stop});
      end else begin
        e = exp_q.pop_front(); t = tag_q.pop_front();
        if ({rsp_retry, rsp_trdy, rsp_stop} !== e) begin
          errs++;
          $display("FAIL %s: actual %b expected %b", t, {rsp_retry, rsp_trdy, rsp_stop}, e);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    errs++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    do_reset();
    check("R11 rsp_valid", rsp_valid, 0);
    check("R11 serr_req", serr_req, 0);
    check("R11 discard_seen", discard_seen, 0);
    check("R11 full", full, 0);

    // R1 R3 R2 R4: single-DWORD delayed write, masked lane differs
    send(32'h1000_0040, 4'b1000, 32'h1122_3344, 0, 3'b100, "R1 first attempt retry");
    send(32'h1000_0040, 4'b1000, 32'h1122_3344, 0, 3'b100, "R3 pending repeat retry");
    fwd(0);
    send(32'h1000_0040, 4'b1000, 32'hFF22_3344, 0, 3'b010, "R2 masked lane ignored, R4 trdy");
    send(32'h1000_0040, 4'b1000, 32'h1122_3344, 0, 3'b100, "R4 entry released, new retry");

    do_reset();
    send(32'h2000_0000, 4'b0000, 32'h0BAD_CAFE, 1, 3'b100, "R1 multi retry");
    fwd(0);
    send(32'h2000_0000, 4'b0000, 32'h0BAD_CAFE, 1, 3'b011, "R4 multi trdy+stop");

    // R2 enabled lane mismatch, R3 no second slot, R6 full
    do_reset();
    send(32'h3000_0000, 4'b0000, 32'hAABB_CCDD, 0, 3'b100, "R1 C");
    fwd(0);
    send(32'h3000_0000, 4'b0000, 32'hAABB_CCDE, 0, 3'b100, "R2 enabled lane differs");
    send(32'h3000_0100, 4'b0000, 32'h0000_0001, 0, 3'b100, "R1 D");
    send(32'h3000_0100, 4'b0000, 32'h0000_0001, 0, 3'b100, "R3 D repeat");
    check("R3 no second slot, full", full, 0);
    send(32'h3000_0200, 4'b0000, 32'h0000_0002, 0, 3'b100, "R1 E");
    check("R6 full set", full, 1);
    send(32'h3000_0300, 4'b0000, 32'h0000_0003, 0, 3'b100, "R6 retry while full");
    check("R6 still full", full, 1);
    send(32'h3000_0000, 4'b0000, 32'hAABB_CCDD, 0, 3'b010, "R4 C done");
    check("R6 slot freed", full, 0);

    do_reset();
    send(32'h4000_0000, 4'b0000, 32'h5, 1, 3'b100, "R1 G");
    fwd(1);
    send(32'h4000_0000, 4'b0000, 32'h5, 1, 3'b001, "R5 failed stop only");

    // R7 R8 discard with serr enabled
    do_reset();
    discard_preload = 16'(P); serr_en = 1'b1;
    send(32'h5000_0000, 4'b0000, 32'h6, 0, 3'b100, "R1 H");
    fwd(0);
    repeat (P) @(negedge clk);
    check("R7 no discard early", serr_req, 0);
    @(negedge clk);
    check("R7 discard on time", serr_req, 1);
    check("R8 sticky set", discard_seen, 1);
    @(negedge clk);
    check("R8 serr one cycle", serr_req, 0);
    send(32'h5000_0000, 4'b0000, 32'h6, 0, 3'b100, "R7 discarded repeat retried");
    check("R8 sticky holds", discard_seen, 1);

    // R8 serr disabled
    do_reset();
    serr_en = 1'b0;
    send(32'h6000_0000, 4'b0000, 32'h7, 0, 3'b100, "R1 K");
    fwd(0);
    repeat (P) @(negedge clk);
    check("R8 gated serr early", serr_req, 0);
    @(negedge clk);
    check("R8 gated serr", serr_req, 0);
    check("R8 gated sticky", discard_seen, 1);

    // R9 fresh count for next head
    do_reset();
    serr_en = 1'b1;
    send(32'h7000_0000, 4'b0000, 32'h8, 0, 3'b100, "R1 I");
    send(32'h7000_0100, 4'b0000, 32'h9, 0, 3'b100, "R1 J");
    fwd(0);
    fwd(0);
    send(32'h7000_0000, 4'b0000, 32'h8, 0, 3'b010, "R4 I consumed");
    repeat (P + 1) @(negedge clk);
    check("R9 J not yet discarded", serr_req, 0);
    @(negedge clk);
    check("R9 J discard fresh count", serr_req, 1);

    repeat (2) @(negedge clk);
    check("R10 all responses seen", exp_q.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule